// File: doc/BRIEF.md
# Byte-Programmed PWM Generator with Auto-Off Timer

This block produces one pulse-width-modulated output whose period and high time are counted in ticks of a fixed time base (nominally 125 ns, from an 8 MHz rate). A host programs it through a write-only byte port made of a strobe, an 8-bit address and an 8-bit data byte. Each 16-bit setting is sent as two bytes. The upper byte is only held in a staging register. The whole value takes effect on the cycle the lower byte is written, so a half-written setting never reaches the output.

An enable bit gates the output. A 16-bit auto-off count, in milliseconds, can switch the block off after a set time. The all-ones count turns this feature off. The output has normal polarity: it is high for the duty part of each period and low for the rest.

Top module: `tick_pwm_unit`

## Requirements
- R1: Writes take effect only when `wr_en` is high and the address is one of 0xA1 to 0xA7. Writes to any other address change nothing. At 0xA3 only data bit 0 is used, as the enable bit.
- R2: A write to 0xA5 only stores the upper period byte. A write to 0xA4 makes the period {stored upper byte, written byte} in the same cycle.
- R3: A write to 0xA7 only stores the upper duty byte. A write to 0xA6 makes the duty {stored upper byte, written byte} in the same cycle.
- R4: While enabled with period P > 0 and duty D, every period lasts P ticks and the output is high for D of them. Over any window of P·CLK_PER_TICK clocks in steady state, the output is high for min(D,P)·CLK_PER_TICK clocks.
- R5: If D ≥ P > 0 while enabled, the output stays high continuously.
- R6: A period of 0 holds the output low.
- R7: While enable is 0, the output is low from the next clock on.
- R8: The period count and tick phase restart from zero on a 0→1 change of enable and on every write to 0xA4.
- R9: A write to 0xA1 only stores the upper auto-off byte. A write to 0xA2 loads the count {stored byte, written byte}. A loaded count of 0xFFFF never clears enable.
- R10: Any other loaded count drops by one every TICKS_PER_MS ticks while enabled. At zero it clears enable. The count is not reloaded, so re-enabling with a count of zero switches off again at once. A host write to 0xA3 wins over expiry in the same cycle.
- R11: Synchronous reset clears all settings, staging bytes and counts to zero, so the block is disabled and the output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_addr | input | 8 | Register address |
| wr_data | input | DATA_W | Write byte |
| pwm_out | output | 1 | Registered PWM output |

## Verification
On every cycle the assertions check these properties: the output is forced low when enable is clear or the period is zero, it is held high at full duty, and an upper-byte write leaves the active period and duty unchanged. They also check that the period count stays inside the period, that an all-ones auto-off count never clears enable, and that the remaining count never rises except on a load. Only the bench scenarios can show the duty ratio over whole periods across a sweep of period and duty values, the restart of a high phase on a period write, the approximate millisecond timing of the auto-off, and the immediate switch-off when the block is re-enabled after expiry.

// File: rtl/tpw_pkg.sv
package tpw_pkg;
  localparam logic [7:0] TPW_A_AOFF_HI = 8'hA1;
  localparam logic [7:0] TPW_A_AOFF_LO = 8'hA2;
  localparam logic [7:0] TPW_A_ENABLE  = 8'hA3;
  localparam logic [7:0] TPW_A_PER_LO  = 8'hA4;
  localparam logic [7:0] TPW_A_PER_HI  = 8'hA5;
  localparam logic [7:0] TPW_A_DUTY_LO = 8'hA6;
  localparam logic [7:0] TPW_A_DUTY_HI = 8'hA7;
endpackage

// File: rtl/tpw_regs.sv
module tpw_regs #(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              expire,
  output logic              en,
  output logic [CNT_W-1:0]  period,
  output logic [CNT_W-1:0]  duty,
  output logic              per_commit,
  output logic              aoff_load,
  output logic [CNT_W-1:0]  aoff_val
);
  import tpw_pkg::*;

  logic [DATA_W-1:0] per_stage, duty_stage, aoff_stage;

  assign per_commit = wr_en && (wr_addr == TPW_A_PER_LO);
  assign aoff_load  = wr_en && (wr_addr == TPW_A_AOFF_LO);
  assign aoff_val   = {aoff_stage, wr_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      en         <= 1'b0;
      period     <= '0;
      duty       <= '0;
      per_stage  <= '0;
      duty_stage <= '0;
      aoff_stage <= '0;
    end else begin
      // expiry first so that a host write to the enable register wins
      if (expire) en <= 1'b0;
      if (wr_en) begin
        case (wr_addr)
          TPW_A_AOFF_HI: aoff_stage <= wr_data;
          TPW_A_ENABLE:  en         <= wr_data[0];
          TPW_A_PER_LO:  period     <= {per_stage, wr_data};
          TPW_A_PER_HI:  per_stage  <= wr_data;
          TPW_A_DUTY_LO: duty       <= {duty_stage, wr_data};
          TPW_A_DUTY_HI: duty_stage <= wr_data;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tpw_tick.sv
module tpw_tick #(
  parameter int CLK_PER_TICK = 8,
  localparam int PW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic tick
);
  generate
    if (CLK_PER_TICK == 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam logic [PW-1:0] LAST = PW'(CLK_PER_TICK - 1);
      logic [PW-1:0] presc;
      always_ff @(posedge clk) begin
        if (rst || clear)       presc <= '0;
        else if (presc == LAST) presc <= '0;
        else                    presc <= presc + 1'b1;
      end
      assign tick = (presc == LAST);
    end
  endgenerate
endmodule

// File: rtl/tpw_core.sv
module tpw_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             en,
  input  logic             per_commit,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty,
  output logic             restart,
  output logic [CNT_W-1:0] cnt,
  output logic             pwm_out
);
  logic en_q;
  logic at_end;

  assign restart = (en && !en_q) || per_commit;
  assign at_end  = (cnt >= period - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= en;
  end

  always_ff @(posedge clk) begin
    if (rst || !en || restart || period == '0) cnt <= '0;
    else if (tick)                             cnt <= at_end ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_out <= 1'b0;
    else     pwm_out <= en && (period != '0) && ((duty >= period) || (cnt < duty));
  end
endmodule

// File: rtl/tpw_autooff.sv
module tpw_autooff #(
  parameter int CNT_W        = 16,
  parameter int TICKS_PER_MS = 8000,
  localparam int MW = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             en,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] remaining,
  output logic             expire
);
  localparam logic [MW-1:0] MS_LAST = MW'(TICKS_PER_MS - 1);

  logic [MW-1:0] ms_cnt;
  logic          armed;
  logic          ms_done;

  assign armed   = (remaining != '1);
  assign ms_done = tick && (ms_cnt == MS_LAST);
  assign expire  = armed && en && (remaining == '0);

  always_ff @(posedge clk) begin
    if (rst || load || !(armed && en)) ms_cnt <= '0;
    else if (ms_done)                  ms_cnt <= '0;
    else if (tick)                     ms_cnt <= ms_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                                               remaining <= '0;
    else if (load)                                         remaining <= load_val;
    else if (armed && en && ms_done && remaining != '0)    remaining <= remaining - 1'b1;
  end
endmodule

// File: rtl/tick_pwm_unit.sv
module tick_pwm_unit #(
  parameter int DATA_W       = 8,
  parameter int CLK_PER_TICK = 8,
  parameter int TICKS_PER_MS = 8000,
  localparam int CNT_W       = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pwm_out
);
  logic             en, per_commit, aoff_load, expire, restart, tick;
  logic [CNT_W-1:0] period, duty, aoff_val, remaining, cnt;

  tpw_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .expire(expire), .en(en), .period(period), .duty(duty),
    .per_commit(per_commit), .aoff_load(aoff_load), .aoff_val(aoff_val)
  );

  tpw_tick #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
    .clk(clk), .rst(rst), .clear(restart), .tick(tick)
  );

  tpw_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .en(en), .per_commit(per_commit),
    .period(period), .duty(duty), .restart(restart), .cnt(cnt), .pwm_out(pwm_out)
  );

  tpw_autooff #(.CNT_W(CNT_W), .TICKS_PER_MS(TICKS_PER_MS)) u_aoff (
    .clk(clk), .rst(rst), .tick(tick), .en(en), .load(aoff_load),
    .load_val(aoff_val), .remaining(remaining), .expire(expire)
  );
endmodule

// File: rtl/tpw_chk.sv
module tpw_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [7:0]       wr_addr,
  input logic             en,
  input logic [CNT_W-1:0] period,
  input logic [CNT_W-1:0] duty,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] remaining,
  input logic             aoff_load,
  input logic             pwm_out
);
  import tpw_pkg::*;

  // R7
  off_when_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pwm_out);

  // R6
  zero_period_low_chk: assert property (@(posedge clk) disable iff (rst)
    (period == '0) |=> !pwm_out);

  // R5
  full_duty_chk: assert property (@(posedge clk) disable iff (rst)
    (en && period != '0 && duty >= period) |=> pwm_out);

  // R2
  per_hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == TPW_A_PER_HI) |=> $stable(period));

  // R3
  duty_hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == TPW_A_DUTY_HI) |=> $stable(duty));

  // R4
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    (period != '0) |-> (cnt < period));

  // R9
  aoff_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (remaining == '1 && en && !(wr_en && wr_addr == TPW_A_ENABLE)) |=> en);

  // R10
  remaining_monotone_chk: assert property (@(posedge clk) disable iff (rst)
    !aoff_load |=> (remaining <= $past(remaining)));
endmodule

bind tick_pwm_unit tpw_chk #(.CNT_W(CNT_W)) u_tpw_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .en(en),
  .period(period), .duty(duty), .cnt(cnt), .remaining(remaining),
  .aoff_load(aoff_load), .pwm_out(pwm_out)
);

// File: tb/tick_pwm_unit_bench.sv
`timescale 1ns/1ps
module tick_pwm_unit_bench;
  localparam int CPT = 2;
  localparam int TPM = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tick_pwm_unit #(.DATA_W(8), .CLK_PER_TICK(CPT), .TICKS_PER_MS(TPM)) u_tick_pwm_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
  endtask

  task automatic set_pd(input int p, input int d);
    wr(8'hA5, 8'(p >> 8));
    wr(8'hA7, 8'(d >> 8));
    wr(8'hA4, 8'(p));
    wr(8'hA6, 8'(d));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi, exp, run;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    check(pwm_out == 1'b0, "R11 reset output", int'(pwm_out), 0);
    wr(8'hA3, 8'h01);
    count_high(20, hi);
    check(hi == 0, "R11 period zero after reset", hi, 0);

    // auto-off off, then sweep period/duty
    wr(8'hA1, 8'hFF);
    wr(8'hA2, 8'hFF);
    wr(8'hA3, 8'h01);
    for (int p = 1; p <= 6; p++) begin
      for (int d = 0; d <= 7; d++) begin
        set_pd(p, d);
        idle(3 * p * CPT + 4);
        count_high(p * CPT, hi);
        exp = ((d < p) ? d : p) * CPT;
        if (d >= p) check(hi == exp, "R5 full duty", hi, exp);
        else        check(hi == exp, "R4 duty ratio", hi, exp);
      end
    end

    // R4 two-byte values
    set_pd(16'h0102, 16'h0081);
    idle(2 * 258 * CPT);
    count_high(258 * CPT, hi);
    check(hi == 16'h81 * CPT, "R4 two-byte period", hi, 16'h81 * CPT);

    // R6 period zero
    set_pd(0, 5);
    idle(4);
    count_high(40, hi);
    check(hi == 0, "R6 zero period", hi, 0);

    // R2 / R3 high-byte staging
    set_pd(4, 2);
    idle(20);
    wr(8'hA5, 8'h01);
    wr(8'hA7, 8'h01);
    idle(2);
    count_high(4 * CPT, hi);
    check(hi == 2 * CPT, "R2 R3 high byte held only", hi, 2 * CPT);
    wr(8'hA4, 8'h00);
    idle(2 * 256 * CPT);
    count_high(256 * CPT, hi);
    check(hi == 2 * CPT, "R2 period committed on low byte", hi, 2 * CPT);
    wr(8'hA6, 8'h00);
    idle(2 * 256 * CPT);
    count_high(256 * CPT, hi);
    check(hi == 256 * CPT, "R3 duty committed on low byte", hi, 256 * CPT);

    // R1 ignored addresses, enable bit 0 only
    set_pd(4, 9);
    idle(4);
    wr(8'hA0, 8'h00);
    wr(8'hA8, 8'h00);
    wr(8'h23, 8'h00);
    idle(2);
    count_high(20, hi);
    check(hi == 20, "R1 other addresses ignored", hi, 20);
    wr(8'hA3, 8'hFE);
    idle(2);
    count_high(20, hi);
    check(hi == 0, "R1 R7 enable bit 0 cleared", hi, 0);

    // R8 restart on enable rise
    set_pd(8, 6);
    wr(8'hA3, 8'h01);
    run = 0;
    while (!pwm_out) @(negedge clk);
    while (pwm_out) begin run++; @(negedge clk); end
    check(run >= 12 && run <= 14, "R8 restart on enable", run, 12);
    // R8 restart on period commit
    while (!pwm_out) @(negedge clk);
    run = 0;
    repeat (4) begin @(negedge clk); run++; end
    @(negedge clk); wr_en = 1'b1; wr_addr = 8'hA4; wr_data = 8'h08; run++;
    @(negedge clk); wr_en = 1'b0; run++;
    while (pwm_out) begin run++; @(negedge clk); end
    check(run >= 15 && run <= 19, "R8 restart on period write", run, 17);

    // R9 / R10 auto-off
    wr(8'hA3, 8'h00);
    set_pd(4, 4);
    wr(8'hA1, 8'h00);
    wr(8'hA2, 8'h03);
    wr(8'hA3, 8'h01);
    run = 0;
    while (!pwm_out && run < 10) begin run++; @(negedge clk); end
    run = 0;
    while (pwm_out && run < 200) begin run++; @(negedge clk); end
    check(run >= 3 * TPM * CPT - 4 && run <= 3 * TPM * CPT + 6, "R10 expiry time", run,
          3 * TPM * CPT);
    count_high(50, hi);
    check(hi == 0, "R10 stays off", hi, 0);
    wr(8'hA3, 8'h01);
    count_high(40, hi);
    check(hi <= 2, "R10 re-enable at zero count", hi, 0);

    wr(8'hA1, 8'hFF);
    wr(8'hA2, 8'hFF);
    wr(8'hA3, 8'h01);
    idle(4);
    count_high(300, hi);
    check(hi == 300, "R9 all-ones count disables auto-off", hi, 300);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule